// File: doc/BRIEF.md
# Calendar Clock Counter Core

This core keeps a time-of-day and calendar set: seconds, minutes, hours, day of week, date, month and a two-digit year. It advances that set by one second each time a one-cycle tick pulse arrives. Software sees every field through a small byte-wide register port. Two mode inputs pick the encoding of every byte: binary or BCD, and a 24-hour or 12-hour clock. In 12-hour mode, bit 7 of the hours byte marks PM. Inside the core the fields are held in binary with a 0–23 hour. Encoding happens only at the read port, the write port and the alarm comparator, so a mode change takes effect on the next access.

A four-state sequencer runs each update. IDLE waits for a tick. A tick with the inhibit input low moves the core to LEAD, and a tick with the inhibit input high is dropped. The core stays in LEAD for `LEAD_CYCLES` cycles with the update-in-progress flag raised, then moves to STEP. STEP lasts one cycle: the flag is still high, and the new field values are loaded at the edge that leaves it. DONE follows for one cycle and pulses the update-done strobe. In that same cycle the core pulses the alarm strobe if the alarm bytes match the new time. DONE always returns to IDLE. Register writes are accepted only in IDLE.

The register map, in byte addresses: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 date, 8 month, 9 year. Other addresses read as zero and ignore writes.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time is 00:00:00, day of week 1, date 1, month 1, year 0, all alarm bytes read 0x00, and the flag and both strobes are low.
- R2: Each update adds one second. Seconds and minutes wrap from 59 to 0 and carry onward. Hours wrap from 23 to 0 and carry into the calendar.
- R3: With the data-mode input low (cfg_binary_i = 0), every time, calendar and alarm byte is written and read as two BCD digits, tens in bits 7:4. With it high, bytes are plain binary.
- R4: With cfg_24h_i low, hours run 12 AM, 1 … 11 AM, 12 PM, 1 … 11 PM. Bit 7 of the hours byte is 1 for PM. 11:59:59 AM becomes hours byte 0x92 in BCD, and 11:59:59 PM becomes 0x12 and advances the date.
- R5: At the last day of a month the date returns to 1 and the month advances. April, June, September and November have 30 days. February has 29 days when the year is divisible by four and 28 otherwise.
- R6: Day of week advances only at midnight and wraps from 7 to 1.
- R7: While cfg_set_i is high, a tick is dropped: no flag, no strobe, and the fields are unchanged.
- R8: The update-in-progress flag rises in the cycle after an accepted tick. It stays high for at least LEAD_CYCLES cycles before any field changes, and it is low in the strobe cycle.
- R9: Each completed update produces exactly one single-cycle update-done pulse.
- R10: The alarm strobe pulses, only together with the update-done pulse, when the seconds, minutes and hours alarm bytes each equal the new time byte in the current encoding. An alarm byte with bits 7:6 both 1 matches any value.
- R11: A write arriving while an update is running (flag high or strobe cycle) is ignored.
- R12: After December 31 the month becomes 1 and the date 1. Year 99 wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| cfg_binary_i | input | 1 | 1 binary bytes, 0 BCD bytes |
| cfg_24h_i | input | 1 | 1 24-hour, 0 12-hour with PM in bit 7 |
| cfg_set_i | input | 1 | Inhibits counting while high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 8 | Write byte |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 8 | Read byte (combinational) |
| uip_o | output | 1 | Update in progress |
| upd_done_o | output | 1 | Update-done strobe |
| alarm_o | output | 1 | Alarm-match strobe |

## Verification
The update-done strobe and the alarm strobe are meant to fire in the same cycle. The bench provokes this by loading an alarm that the new time will hit, both through exact bytes and through don't-care bytes. It then samples both strobes in the one cycle where the update-done strobe is high, and judges that the alarm is high there and low one update later when the seconds no longer match. Register writes and a running update also meet each other. The bench lands a write in the middle of the update-in-progress window and judges that the seconds show the advanced count, not the written value.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LEAD = 2'd1,
        S_STEP = 2'd2,
        S_DONE = 2'd3
    } seq_state_e;

    localparam int NUM_FIELDS = 7;
    localparam int NUM_ALARMS = 3;
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;

    localparam logic [3:0] A_SEC   = 4'd0;
    localparam logic [3:0] A_ASEC  = 4'd1;
    localparam logic [3:0] A_MIN   = 4'd2;
    localparam logic [3:0] A_AMIN  = 4'd3;
    localparam logic [3:0] A_HOUR  = 4'd4;
    localparam logic [3:0] A_AHOUR = 4'd5;
    localparam logic [3:0] A_DOW   = 4'd6;
    localparam logic [3:0] A_DATE  = 4'd7;
    localparam logic [3:0] A_MON   = 4'd8;
    localparam logic [3:0] A_YEAR  = 4'd9;

    localparam logic [7:0] MS_MAX    = 8'd59;
    localparam logic [7:0] HOUR_MAX  = 8'd23;
    localparam logic [7:0] DOW_MAX   = 8'd7;
    localparam logic [7:0] MON_MAX   = 8'd12;
    localparam logic [7:0] YEAR_MAX  = 8'd99;
    localparam logic [7:0] NOON      = 8'd12;

    function automatic logic [7:0] to_bcd(input logic [7:0] v);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v - tens * 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [7:0] from_bcd(input logic [7:0] b);
        return {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
    endfunction

    function automatic logic [7:0] enc_byte(input logic [7:0] v, input logic bin);
        return bin ? v : to_bcd(v);
    endfunction

    function automatic logic [7:0] dec_byte(input logic [7:0] b, input logic bin);
        return bin ? b : from_bcd(b);
    endfunction

    function automatic logic [7:0] enc_hour(input logic [7:0] h, input logic bin,
                                            input logic h24);
        logic [7:0] h12;
        logic [7:0] e;
        if (h24) begin
            return enc_byte(h, bin);
        end
        if (h == 8'd0)      h12 = NOON;
        else if (h > NOON)  h12 = h - NOON;
        else                h12 = h;
        e = enc_byte(h12, bin);
        return {(h >= NOON), e[6:0]};
    endfunction

    function automatic logic [7:0] dec_hour(input logic [7:0] b, input logic bin,
                                            input logic h24);
        logic [7:0] v;
        logic [7:0] base;
        if (h24) begin
            return dec_byte(b, bin);
        end
        v    = dec_byte({1'b0, b[6:0]}, bin);
        base = (v == NOON) ? 8'd0 : v;
        return b[7] ? base + NOON : base;
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] m, input logic [7:0] y);
        logic [7:0] d;
        unique case (m)
            8'd2:                    d = (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: d = 8'd30;
            default:                 d = 8'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_cal_seq.sv
module rtc_cal_seq
    import rtc_cal_pkg::*;
#(
    parameter int LEAD_CYCLES = 12200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic set_i,
    output logic uip_o,
    output logic step_o,
    output logic done_o,
    output logic idle_o
);

    localparam int CNT_W = $clog2(LEAD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LEAD_CYCLES - 1);

    seq_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                cnt_d = '0;
                if (tick_i && !set_i) state_d = S_LEAD;
            end
            S_LEAD: begin
                if (cnt_q == LAST) begin
                    state_d = S_STEP;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_STEP: state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        uip_o  = 1'b0;
        step_o = 1'b0;
        done_o = 1'b0;
        idle_o = 1'b0;
        unique case (state_q)
            S_IDLE: idle_o = 1'b1;
            S_LEAD: uip_o  = 1'b1;
            S_STEP: begin
                uip_o  = 1'b1;
                step_o = 1'b1;
            end
            S_DONE: done_o = 1'b1;
            default: idle_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_cal_next.sv
module rtc_cal_next
    import rtc_cal_pkg::*;
(
    input  cal_t cur_i,
    output cal_t nxt_o
);

    logic [7:0] last_day;
    assign last_day = month_days(cur_i.month, cur_i.year);

    always_comb begin
        nxt_o = cur_i;
        if (cur_i.sec < MS_MAX) begin
            nxt_o.sec = cur_i.sec + 8'd1;
        end else begin
            nxt_o.sec = 8'd0;
            if (cur_i.min < MS_MAX) begin
                nxt_o.min = cur_i.min + 8'd1;
            end else begin
                nxt_o.min = 8'd0;
                if (cur_i.hour < HOUR_MAX) begin
                    nxt_o.hour = cur_i.hour + 8'd1;
                end else begin
                    nxt_o.hour = 8'd0;
                    nxt_o.dow  = (cur_i.dow >= DOW_MAX) ? 8'd1 : cur_i.dow + 8'd1;
                    if (cur_i.date < last_day) begin
                        nxt_o.date = cur_i.date + 8'd1;
                    end else begin
                        nxt_o.date = 8'd1;
                        if (cur_i.month < MON_MAX) begin
                            nxt_o.month = cur_i.month + 8'd1;
                        end else begin
                            nxt_o.month = 8'd1;
                            nxt_o.year  = (cur_i.year >= YEAR_MAX) ? 8'd0
                                                                   : cur_i.year + 8'd1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rtc_cal_view.sv
module rtc_cal_view
    import rtc_cal_pkg::*;
(
    input  cal_t                          cur_i,
    input  logic                          bin_i,
    input  logic                          h24_i,
    output logic [NUM_FIELDS-1:0][7:0]    enc_o
);

    logic [NUM_FIELDS-1:0][7:0] raw;
    assign raw = cur_i;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        if (i == F_HOUR) begin : g_hour
            assign enc_o[i] = enc_hour(raw[i], bin_i, h24_i);
        end else begin : g_plain
            assign enc_o[i] = enc_byte(raw[i], bin_i);
        end
    end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int LEAD_CYCLES = 12200,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cfg_binary_i,
    input  logic              cfg_24h_i,
    input  logic              cfg_set_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              uip_o,
    output logic              upd_done_o,
    output logic              alarm_o
);

    localparam cal_t CAL_RST = '{year: 8'd0, month: 8'd1, date: 8'd1, dow: 8'd1,
                                 hour: 8'd0, min: 8'd0, sec: 8'd0};

    cal_t cur_q;
    cal_t nxt;
    logic [NUM_ALARMS-1:0][7:0] al_q;
    logic [NUM_FIELDS-1:0][7:0] enc;
    logic [NUM_ALARMS-1:0]      hit;
    logic step, done, idle;
    logic [7:0] sec_bin;
    logic [7:0] wbyte;
    logic [3:0] waddr;
    logic [3:0] raddr;

    assign wbyte   = wr_data_i[7:0];
    assign waddr   = 4'(wr_addr_i);
    assign raddr   = 4'(rd_addr_i);
    assign sec_bin = cur_q.sec;

    rtc_cal_seq #(.LEAD_CYCLES(LEAD_CYCLES)) i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .set_i  (cfg_set_i),
        .uip_o  (uip_o),
        .step_o (step),
        .done_o (done),
        .idle_o (idle)
    );

    rtc_cal_next i_next (
        .cur_i (cur_q),
        .nxt_o (nxt)
    );

    rtc_cal_view i_view (
        .cur_i (cur_q),
        .bin_i (cfg_binary_i),
        .h24_i (cfg_24h_i),
        .enc_o (enc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= CAL_RST;
            al_q  <= '0;
        end else if (step) begin
            cur_q <= nxt;
        end else if (wr_en_i && idle) begin
            unique case (waddr)
                A_SEC:   cur_q.sec   <= dec_byte(wbyte, cfg_binary_i);
                A_MIN:   cur_q.min   <= dec_byte(wbyte, cfg_binary_i);
                A_HOUR:  cur_q.hour  <= dec_hour(wbyte, cfg_binary_i, cfg_24h_i);
                A_DOW:   cur_q.dow   <= dec_byte(wbyte, cfg_binary_i);
                A_DATE:  cur_q.date  <= dec_byte(wbyte, cfg_binary_i);
                A_MON:   cur_q.month <= dec_byte(wbyte, cfg_binary_i);
                A_YEAR:  cur_q.year  <= dec_byte(wbyte, cfg_binary_i);
                A_ASEC:  al_q[F_SEC]  <= wbyte;
                A_AMIN:  al_q[F_MIN]  <= wbyte;
                A_AHOUR: al_q[F_HOUR] <= wbyte;
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
        assign hit[i] = (al_q[i][7:6] == 2'b11) || (al_q[i] == enc[i]);
    end

    assign upd_done_o = done;
    assign alarm_o    = done && (&hit);

    always_comb begin
        rd_data_o = '0;
        unique case (raddr)
            A_SEC:   rd_data_o = DATA_W'(enc[0]);
            A_ASEC:  rd_data_o = DATA_W'(al_q[F_SEC]);
            A_MIN:   rd_data_o = DATA_W'(enc[1]);
            A_AMIN:  rd_data_o = DATA_W'(al_q[F_MIN]);
            A_HOUR:  rd_data_o = DATA_W'(enc[2]);
            A_AHOUR: rd_data_o = DATA_W'(al_q[F_HOUR]);
            A_DOW:   rd_data_o = DATA_W'(enc[3]);
            A_DATE:  rd_data_o = DATA_W'(enc[4]);
            A_MON:   rd_data_o = DATA_W'(enc[5]);
            A_YEAR:  rd_data_o = DATA_W'(enc[6]);
            default: rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk #(
    parameter int LEAD_CYCLES = 12200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       cfg_set_i,
    input logic       uip_o,
    input logic       upd_done_o,
    input logic       alarm_o,
    input logic [7:0] sec_bin
);

    localparam int RW = $clog2(LEAD_CYCLES + 2);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else if (!uip_o) run_q <= '0;
        else if (run_q < RW'(LEAD_CYCLES + 1)) run_q <= run_q + 1'b1;
    end

    p_uip_lead_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done_o |-> (run_q >= RW'(LEAD_CYCLES)));

    p_uip_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip_o) |-> ($past(tick_i) && !$past(cfg_set_i)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done_o |=> !upd_done_o);

    p_done_after_uip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done_o |-> ($past(uip_o) && !uip_o));

    p_alarm_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> upd_done_o);

    p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bin <= 8'd59);

endmodule

bind rtc_calendar_core rtc_cal_chk #(.LEAD_CYCLES(LEAD_CYCLES)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .cfg_set_i  (cfg_set_i),
    .uip_o      (uip_o),
    .upd_done_o (upd_done_o),
    .alarm_o    (alarm_o),
    .sec_bin    (sec_bin)
);

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;

    localparam int LEAD = 8;
    localparam logic [3:0] SEC = 4'd0, ASEC = 4'd1, MIN = 4'd2, AMIN = 4'd3,
                           HR = 4'd4, AHR = 4'd5, DOW = 4'd6, DATE = 4'd7,
                           MON = 4'd8, YR = 4'd9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic bin = 1'b1;
    logic h24 = 1'b1;
    logic set = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic uip, done, alarm;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    rtc_calendar_core #(.LEAD_CYCLES(LEAD)) i_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .cfg_binary_i(bin),
        .cfg_24h_i(h24), .cfg_set_i(set), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .uip_o(uip), .upd_done_o(done), .alarm_o(alarm)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(HR, h); wr(MIN, m); wr(SEC, s);
    endtask

    task automatic set_cal(input logic [7:0] w, input logic [7:0] d,
                           input logic [7:0] mo, input logic [7:0] y);
        wr(DOW, w); wr(DATE, d); wr(MON, mo); wr(YR, y);
    endtask

    task automatic run_update(output int nuip, output logic seen, output logic al,
                              output logic again);
        nuip = 0; seen = 0; al = 0; again = 0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        for (int k = 0; k < 100; k++) begin
            if (done) break;
            if (uip) nuip++;
            @(negedge clk);
        end
        seen = done; al = alarm;
        @(negedge clk);
        again = done;
    endtask

    task automatic step1();
        int n; logic s, a, g;
        run_update(n, s, a, g);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(SEC, v);  chk("R1 sec", v, 8'd0);
        rd(HR, v);   chk("R1 hour", v, 8'd0);
        rd(DOW, v);  chk("R1 dow", v, 8'd1);
        rd(DATE, v); chk("R1 date", v, 8'd1);
        rd(MON, v);  chk("R1 month", v, 8'd1);
        rd(YR, v);   chk("R1 year", v, 8'd0);
        rd(AHR, v);  chk("R1 alarm", v, 8'd0);
        chk("R1 flags", {5'd0, uip, done, alarm}, 8'd0);
    endtask

    task automatic t_rollover();
        logic [7:0] v;
        bin = 1; h24 = 1;
        set_cal(8'd3, 8'd15, 8'd5, 8'd30);
        set_hms(8'd4, 8'd7, 8'd10);
        step1();
        rd(SEC, v); chk("R2 plain sec", v, 8'd11);
        rd(MIN, v); chk("R2 plain min", v, 8'd7);
        set_hms(8'd23, 8'd59, 8'd59);
        step1();
        rd(SEC, v);  chk("R2 sec wrap", v, 8'd0);
        rd(MIN, v);  chk("R2 min wrap", v, 8'd0);
        rd(HR, v);   chk("R2 hour wrap", v, 8'd0);
        rd(DATE, v); chk("R2 date carry", v, 8'd16);
        rd(DOW, v);  chk("R6 dow midnight", v, 8'd4);
    endtask

    task automatic t_bcd();
        logic [7:0] v;
        bin = 0; h24 = 1;
        set_hms(8'h19, 8'h09, 8'h59);
        step1();
        rd(SEC, v); chk("R3 bcd sec", v, 8'h00);
        rd(MIN, v); chk("R3 bcd min", v, 8'h10);
        rd(HR, v);  chk("R3 bcd hour", v, 8'h19);
        bin = 1;
        rd(MIN, v); chk("R3 binary view", v, 8'd10);
    endtask

    task automatic t_12h();
        logic [7:0] v;
        bin = 0; h24 = 0;
        set_cal(8'd2, 8'h10, 8'h03, 8'h21);
        set_hms(8'h11, 8'h59, 8'h59);
        step1();
        rd(HR, v);   chk("R4 noon", v, 8'h92);
        rd(DATE, v); chk("R4 no date step at noon", v, 8'h10);
        set_hms(8'h91, 8'h59, 8'h59);
        step1();
        rd(HR, v);   chk("R4 midnight", v, 8'h12);
        rd(DATE, v); chk("R4 date step", v, 8'h11);
        bin = 1; h24 = 1;
    endtask

    task automatic t_month();
        logic [7:0] v;
        bin = 1; h24 = 1;
        set_cal(8'd1, 8'd30, 8'd4, 8'd22);
        set_hms(8'd23, 8'd59, 8'd59);
        step1();
        rd(DATE, v); chk("R5 april date", v, 8'd1);
        rd(MON, v);  chk("R5 april month", v, 8'd5);
        set_cal(8'd1, 8'd28, 8'd2, 8'd23);
        set_hms(8'd23, 8'd59, 8'd59);
        step1();
        rd(MON, v);  chk("R5 feb common", v, 8'd3);
        set_cal(8'd1, 8'd28, 8'd2, 8'd24);
        set_hms(8'd23, 8'd59, 8'd59);
        step1();
        rd(DATE, v); chk("R5 feb leap 29", v, 8'd29);
        set_hms(8'd23, 8'd59, 8'd59);
        step1();
        rd(DATE, v); chk("R5 leap end date", v, 8'd1);
        rd(MON, v);  chk("R5 leap end month", v, 8'd3);
    endtask

    task automatic t_dow_year();
        logic [7:0] v;
        bin = 1; h24 = 1;
        set_cal(8'd7, 8'd31, 8'd12, 8'd99);
        set_hms(8'd12, 8'd0, 8'd0);
        step1();
        rd(DOW, v); chk("R6 dow held midday", v, 8'd7);
        set_hms(8'd23, 8'd59, 8'd59);
        step1();
        rd(DOW, v);  chk("R6 dow wrap", v, 8'd1);
        rd(DATE, v); chk("R12 date", v, 8'd1);
        rd(MON, v);  chk("R12 month", v, 8'd1);
        rd(YR, v);   chk("R12 year", v, 8'd0);
    endtask

    task automatic t_set();
        logic [7:0] v;
        logic seen_any;
        bin = 1; h24 = 1;
        set_hms(8'd1, 8'd1, 8'd20);
        set = 1;
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        seen_any = 0;
        for (int k = 0; k < LEAD + 6; k++) begin
            if (uip || done) seen_any = 1;
            @(negedge clk);
        end
        chk("R7 no activity", {7'd0, seen_any}, 8'd0);
        rd(SEC, v); chk("R7 sec held", v, 8'd20);
        set = 0;
    endtask

    task automatic t_timing();
        int n; logic s, a, g;
        logic [7:0] v;
        bin = 1; h24 = 1;
        set_hms(8'd2, 8'd2, 8'd30);
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        chk("R8 uip rises", {7'd0, uip}, 8'd1);
        repeat (LEAD - 1) @(negedge clk);
        rd(SEC, v); chk("R8 stable in lead", v, 8'd30);
        repeat (2) @(negedge clk);
        chk("R9 done", {7'd0, done}, 8'd1);
        chk("R8 uip low at strobe", {7'd0, uip}, 8'd0);
        @(negedge clk);
        chk("R9 single pulse", {7'd0, done}, 8'd0);
        run_update(n, s, a, g);
        chk("R8 lead length", 8'(n), 8'(LEAD + 1));
        chk("R9 seen", {7'd0, s}, 8'd1);
        chk("R9 no repeat", {7'd0, g}, 8'd0);
    endtask

    task automatic t_alarm();
        int n; logic s, a, g;
        bin = 1; h24 = 1;
        wr(ASEC, 8'd5); wr(AMIN, 8'hC0); wr(AHR, 8'hC0);
        set_hms(8'd9, 8'd9, 8'd4);
        run_update(n, s, a, g);
        chk("R10 wildcard hit", {6'd0, s, a}, 8'd3);
        run_update(n, s, a, g);
        chk("R10 sec miss", {6'd0, s, a}, 8'd2);
        wr(ASEC, 8'd30); wr(AMIN, 8'd20); wr(AHR, 8'd10);
        set_hms(8'd10, 8'd20, 8'd29);
        run_update(n, s, a, g);
        chk("R10 exact hit", {6'd0, s, a}, 8'd3);
        bin = 0;
        wr(ASEC, 8'h45); wr(AMIN, 8'hC0); wr(AHR, 8'hFF);
        set_hms(8'h00, 8'h00, 8'h44);
        run_update(n, s, a, g);
        chk("R10 bcd hit", {6'd0, s, a}, 8'd3);
        bin = 1;
    endtask

    task automatic t_busy();
        logic [7:0] v;
        bin = 1; h24 = 1;
        set_hms(8'd3, 8'd3, 8'd10);
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        repeat (2) @(negedge clk);
        wr_en = 1; wr_addr = SEC; wr_data = 8'd40;
        @(negedge clk); wr_en = 0;
        repeat (LEAD + 4) @(negedge clk);
        rd(SEC, v); chk("R11 write dropped", v, 8'd11);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_rollover();
        t_bcd();
        t_12h();
        t_month();
        t_dow_year();
        t_set();
        t_timing();
        t_alarm();
        t_busy();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule